// File: doc/BRIEF.md
# GPIO Interrupt Cause Controller

This block is the interrupt front end for a bank of 32 general-purpose input lines. It first synchronizes each pin with two flops. It then passes the pin through a per-line inverter under software control. The result is the visible data-in word.

Two cause sources are formed from data-in:

- **Level cause.** The data-in word itself, gated by a level mask.
- **Edge cause.** A sticky register that records every 0-to-1 transition of data-in, gated by an edge mask.

For each line the two masked causes are ORed. The result is then qualified by the line's input-enable bit in the I/O configuration register. Each run of eight consecutive lines is ORed into one summary interrupt toward the main interrupt controller.

Software reaches the registers through a single-cycle write strobe, an address and a combinational read port. Edge causes are acknowledged by writing a word with a 0 in each bit to clear. A 1 leaves that bit alone. Flipping a polarity bit on a steady line creates a data-in rising edge when data-in goes 0 to 1. Software uses this to catch the opposite pin transition, which emulates both-edge detection.

Top module: `gpio_irq_cause`

## Requirements
- R1: The data-in word, read at address 1, equals the synchronized pin level XOR the polarity register (address 2). A polarity bit of 1 inverts that line.
- R2: A pin change appears in data-in after exactly two rising clock edges. After one edge, data-in still shows the old value.
- R3: Level cause for a line is its data-in bit ANDed with the level mask bit (address 5).
- R4: A 0-to-1 transition of a data-in bit sets that bit in the edge-cause register (address 3) at the next clock edge. The bit stays set after data-in returns to 0. A 1-to-0 transition sets nothing.
- R5: Edge cause contributes to the interrupt only where the edge mask bit (address 4) is 1.
- R6: Summary output irq_o[g] is the OR over lines 8g to 8g+7 of the qualified per-line cause.
- R7: A write to address 3 clears each edge-cause bit written as 0 and leaves each bit written as 1 unchanged.
- R8: After reset, every register reads 0 and irq_o is 0.
- R9: A line contributes to irq_o only while its bit in the I/O configuration register (address 0) is 1, meaning input.
- R10: When a data-in rising edge on a bit coincides with a write-0 clear of that bit, the bit stays set.
- R11: Edges are recorded while the edge mask bit is 0. Setting the mask bit later raises the interrupt immediately.
- R12: Changing a polarity bit so that data-in goes 0 to 1 on a steady pin records an edge cause for that line.
- R13: Writes to address 1 have no effect. Reads from unused addresses 6 and 7 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pin_i | input | 32 | Asynchronous GPIO pin levels |
| we_i | input | 1 | Register write strobe, one cycle per write |
| addr_i | input | 3 | Register address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for addr_i |
| irq_o | output | 4 | Summary interrupt per group of eight lines |

## Verification
Two functions can land in the same clock edge on one edge-cause bit: a new rising edge of data-in and a software write-0 acknowledge of that bit.

The bench provokes the collision in three steps:

1. It sets the bit, lets the pin fall and raise again.
2. It counts two edges so the synchronized rise is pending.
3. It issues the clearing write on exactly the next edge.

The bit must read back as 1. A second bit cleared in the same write, with no edge pending, must read back as 0. A lone clear on the following cycle then confirms that the acknowledge itself works.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned ADDR_W = 3;

  typedef enum logic [ADDR_W-1:0] {
    REG_DIR    = 3'd0,
    REG_DIN    = 3'd1,
    REG_POL    = 3'd2,
    REG_ECAUSE = 3'd3,
    REG_EMASK  = 3'd4,
    REG_LMASK  = 3'd5
  } reg_addr_e;
endpackage

// File: rtl/gpio_irq_sync.sv
module gpio_irq_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= d_i;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_irq_regs.sv
module gpio_irq_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned WIDTH = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  input  logic [WIDTH-1:0]  din_i,
  input  logic [WIDTH-1:0]  ecause_i,
  output logic [WIDTH-1:0]  rdata_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  pol_o,
  output logic [WIDTH-1:0]  emask_o,
  output logic [WIDTH-1:0]  lmask_o,
  output logic [WIDTH-1:0]  ec_keep_o
);
  logic [WIDTH-1:0] dir_q, pol_q, emask_q, lmask_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q   <= '0;
      pol_q   <= '0;
      emask_q <= '0;
      lmask_q <= '0;
    end else if (we_i) begin
      unique case (addr_i)
        REG_DIR:   dir_q   <= wdata_i;
        REG_POL:   pol_q   <= wdata_i;
        REG_EMASK: emask_q <= wdata_i;
        REG_LMASK: lmask_q <= wdata_i;
        default: ;
      endcase
    end
  end

  // write-0-to-clear keep mask for the edge-cause register
  assign ec_keep_o = (we_i && addr_i == REG_ECAUSE) ? wdata_i : '1;

  always_comb begin
    unique case (addr_i)
      REG_DIR:    rdata_o = dir_q;
      REG_DIN:    rdata_o = din_i;
      REG_POL:    rdata_o = pol_q;
      REG_ECAUSE: rdata_o = ecause_i;
      REG_EMASK:  rdata_o = emask_q;
      REG_LMASK:  rdata_o = lmask_q;
      default:    rdata_o = '0;
    endcase
  end

  assign dir_o   = dir_q;
  assign pol_o   = pol_q;
  assign emask_o = emask_q;
  assign lmask_o = lmask_q;
endmodule

// File: rtl/gpio_irq_edge.sv
module gpio_irq_edge #(
  parameter int unsigned WIDTH = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] din_i,
  input  logic [WIDTH-1:0] keep_i,
  output logic [WIDTH-1:0] ecause_o
);
  logic [WIDTH-1:0] din_q, ec_q, rise;

  assign rise = din_i & ~din_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      din_q <= '0;
      ec_q  <= '0;
    end else begin
      din_q <= din_i;
      ec_q  <= (ec_q & keep_i) | rise;  // new edge beats clear
    end
  end

  assign ecause_o = ec_q;
endmodule

// File: rtl/gpio_irq_group.sv
module gpio_irq_group #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned GROUP = 8,
  localparam int unsigned NGRP = WIDTH / GROUP
) (
  input  logic [WIDTH-1:0] cause_i,
  output logic [NGRP-1:0]  irq_o
);
  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    assign irq_o[g] = |cause_i[g*GROUP +: GROUP];
  end
endmodule

// File: rtl/gpio_irq_cause.sv
module gpio_irq_cause
  import gpio_irq_pkg::*;
#(
  parameter int unsigned NUM_LINES  = 32,
  parameter int unsigned GROUP_SIZE = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NUM_GROUPS = NUM_LINES / GROUP_SIZE
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NUM_LINES-1:0]  pin_i,
  input  logic                  we_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic [NUM_LINES-1:0]  wdata_i,
  output logic [NUM_LINES-1:0]  rdata_o,
  output logic [NUM_GROUPS-1:0] irq_o
);
  logic [NUM_LINES-1:0] pin_s, din, ecause, dir, pol, emask, lmask, ec_keep, cause;

  gpio_irq_sync #(.WIDTH(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(pin_s)
  );

  assign din = pin_s ^ pol;

  gpio_irq_regs #(.WIDTH(NUM_LINES)) u_regs (
    .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
    .din_i(din), .ecause_i(ecause), .rdata_o,
    .dir_o(dir), .pol_o(pol), .emask_o(emask), .lmask_o(lmask),
    .ec_keep_o(ec_keep)
  );

  gpio_irq_edge #(.WIDTH(NUM_LINES)) u_edge (
    .clk_i, .rst_ni, .din_i(din), .keep_i(ec_keep), .ecause_o(ecause)
  );

  assign cause = dir & ((din & lmask) | (ecause & emask));

  gpio_irq_group #(.WIDTH(NUM_LINES), .GROUP(GROUP_SIZE)) u_group (
    .cause_i(cause), .irq_o
  );
endmodule

// File: rtl/gpio_irq_cause_chk.sv
module gpio_irq_cause_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned W  = 32,
  parameter int unsigned NG = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [W-1:0]      wdata_i,
  input logic [W-1:0]      din,
  input logic [W-1:0]      ecause,
  input logic [W-1:0]      dir,
  input logic [W-1:0]      emask,
  input logic [W-1:0]      lmask,
  input logic [NG-1:0]     irq_o
);
  logic past_valid;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_valid <= 1'b0;
    else         past_valid <= 1'b1;

  // R7: an edge-cause bit only drops where a clearing write wrote 0
  assert_clear_only_by_write_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid |-> (($past(ecause) & ~ecause &
      ~(($past(we_i) && $past(addr_i) == REG_ECAUSE) ? ~$past(wdata_i) : '0)) == '0));

  // R4: a newly set edge-cause bit needs data-in high in the previous cycle
  assert_edge_needs_din_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid |-> ((ecause & ~$past(ecause) & ~$past(din)) == '0));

  // R9: no summary interrupt without an enabled, unmasked input
  assert_irq_needs_enable_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o != '0) |-> ((dir & (lmask | emask)) != '0));

  // R10: a rising edge always ends up set at the next edge
  assert_edge_wins_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_valid |-> (($past(din) & ~$past(din, 2) & ~ecause) == '0 || !$past(past_valid)));

  // R8
  always @(posedge clk_i)
    if (!rst_ni) assert_reset_quiet_R8: assert (irq_o == '0);
endmodule

bind gpio_irq_cause gpio_irq_cause_chk #(.W(NUM_LINES), .NG(NUM_GROUPS)) u_chk (
  .clk_i, .rst_ni, .we_i, .addr_i, .wdata_i,
  .din, .ecause, .dir, .emask, .lmask, .irq_o
);

// File: tb/gpio_irq_cause_tb_top.sv
module gpio_irq_cause_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [31:0] pin_i;
  logic        we_i;
  logic [2:0]  addr_i;
  logic [31:0] wdata_i;
  logic [31:0] rdata_o;
  logic [3:0]  irq_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  gpio_irq_cause dut_i (
    .clk_i, .rst_ni, .pin_i, .we_i, .addr_i, .wdata_i, .rdata_o, .irq_o
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk_i);
      #1;
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    step();
    we_i = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr_i = a;
    #1;
    d = rdata_o;
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; pin_i = '0; we_i = 1'b0; addr_i = '0; wdata_i = '0;
    #(CLK_PERIOD*2);
    @(negedge clk_i);
    rst_ni = 1'b1;
    step();
  endtask

  task automatic t_reset();
    logic [31:0] v;
    do_reset();
    for (int a = 0; a < 8; a++) begin
      rd(a[2:0], v);
      check("R8 reset reg", v, 32'h0);
    end
    check("R8 reset irq", {28'h0, irq_o}, 32'h0);
  endtask

  task automatic t_polarity();
    logic [31:0] v;
    do_reset();
    pin_i = 32'h0000_A5A5;
    step();
    rd(3'd1, v); check("R2 one edge", v, 32'h0);
    step();
    rd(3'd1, v); check("R2 two edges", v, 32'h0000_A5A5);
    wr(3'd2, 32'h0000_FFFF);
    rd(3'd1, v); check("R1 inverted", v, 32'h0000_5A5A);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, v); check("R13 din write ignored", v, 32'h0000_5A5A);
    wr(3'd6, 32'hFFFF_FFFF);
    rd(3'd6, v); check("R13 unused addr", v, 32'h0);
  endtask

  task automatic t_level();
    do_reset();
    wr(3'd5, 32'h0100_0000);
    pin_i = 32'h0100_0000;
    step(2);
    check("R9 dir off", {28'h0, irq_o}, 32'h0);
    wr(3'd0, 32'h0100_0000);
    check("R9 dir on", {28'h0, irq_o}, 32'h8);
    check("R3 level on", {28'h0, irq_o}, 32'h8);
    pin_i = 32'h0;
    step(2);
    check("R3 level off", {28'h0, irq_o}, 32'h0);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd5, 32'hFFFF_FFFF);
    foreach (lines[i]) begin
      pin_i = 32'h1 << lines[i];
      step(2);
      check("R6 group map", {28'h0, irq_o}, 32'h1 << (lines[i] / 8));
    end
    pin_i = 32'h0;
    wr(3'd5, 32'hFFFF_FEFF);
    pin_i = 32'h0000_0100;
    step(2);
    check("R3 masked line", {28'h0, irq_o}, 32'h0);
  endtask
  int lines[7] = '{0, 7, 8, 15, 16, 23, 31};

  task automatic t_edge();
    logic [31:0] v;
    do_reset();
    wr(3'd0, 32'hFFFF_FFFF);
    pin_i = 32'h0000_0008;
    step(2);
    rd(3'd3, v); check("R4 not yet", v, 32'h0);
    step();
    rd(3'd3, v); check("R4 latched", v, 32'h8);
    check("R5 masked edge", {28'h0, irq_o}, 32'h0);
    pin_i = 32'h0;
    step(3);
    rd(3'd3, v); check("R4 sticky no fall", v, 32'h8);
    wr(3'd4, 32'h0000_0008);
    check("R11 pending exposed", {28'h0, irq_o}, 32'h1);
    wr(3'd4, 32'h0);
    check("R5 remasked", {28'h0, irq_o}, 32'h0);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    do_reset();
    pin_i = 32'h0000_0006;
    step(3);
    rd(3'd3, v); check("R4 two bits", v, 32'h6);
    wr(3'd3, ~32'h2);
    rd(3'd3, v); check("R7 clear one", v, 32'h4);
    wr(3'd3, 32'hFFFF_FFFF);
    rd(3'd3, v); check("R7 ones keep", v, 32'h4);
  endtask

  task automatic t_collide();
    logic [31:0] v;
    do_reset();
    pin_i = 32'h0000_0600;
    step(3);
    rd(3'd3, v); check("R4 pre-set", v, 32'h600);
    pin_i = 32'h0000_0400;
    step(2);
    pin_i = 32'h0000_0600;
    step(2);
    wr(3'd3, 32'h0);
    rd(3'd3, v); check("R10 edge wins", v, 32'h200);
    wr(3'd3, 32'h0);
    rd(3'd3, v); check("R7 later clear", v, 32'h0);
  endtask

  task automatic t_pol_edge();
    logic [31:0] v;
    do_reset();
    wr(3'd0, 32'h1);
    wr(3'd4, 32'h1);
    wr(3'd2, 32'h1);
    rd(3'd3, v); check("R12 not yet", v, 32'h0);
    step();
    rd(3'd3, v); check("R12 pol edge", v, 32'h1);
    check("R12 irq", {28'h0, irq_o}, 32'h1);
    wr(3'd3, 32'h0);
    wr(3'd2, 32'h0);
    step(2);
    rd(3'd3, v); check("R12 falling no edge", v, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD*100000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_polarity();
    t_level();
    t_edge();
    t_clear();
    t_collide();
    t_pol_edge();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule